// File: doc/BRIEF.md
# Register-Register ALU with Condition Flags

This block runs the two-register data-processing group of a small processor whose instructions are 16 bits wide. Each cycle it receives an instruction word with a valid strobe. It also receives the two 32-bit operand values that the surrounding register file has already read: one for the source field and one for the source/destination field. It returns the computed value, a write-enable and the index of the register to write. The condition flags N, Z, C and V are held in a register inside the block and are loaded on the clock edge that completes a recognised instruction.

The datapath is combinational from the operand inputs to `res`, `wr_en` and `wr_idx`, so a surrounding pipeline can write the register file on the same edge that loads the flags. The sixteen operations share one format. Logic, shift-by-register, add and subtract with carry, multiply, negate and the compare forms that only set flags are selected by a four-bit code.

Top module: `regop_alu`

## Requirements
- R1: An instruction is recognised only when `instr_vld` is 1 and `instr[15:10]` is 6'b010000. For an unrecognised instruction, `wr_en` is 0 and `flags` holds its value. For a recognised one, `wr_idx` equals `instr[2:0]`.
- R2: The opcode is `instr[9:6]`. Codes 8 (TST), 10 (CMP) and 11 (CMN) update the flags and keep `wr_en` at 0. Every other recognised code raises `wr_en`.
- R3: `flags` is packed as {N,Z,C,V} (bit 3 is N, bit 0 is V). After every recognised instruction, N is bit 31 of the computed value and Z is 1 exactly when that value is zero.
- R4: In the operand naming, S is `src_val` (the register in bits 5:3) and D is `dst_val` (the register in bits 2:0). The logic codes are AND=0 (D&S), EOR=1 (D^S), TST=8 (D&S), ORR=12 (D|S), BIC=14 (D&~S) and MVN=15 (~S). All of them leave C and V unchanged.
- R5: The shift codes are LSL=2, LSR=3, ASR=4 and ROR=7. They shift D by the amount in S[7:0], and C takes the last bit shifted out. An amount of 32 or more gives zero for LSL and LSR, and sign fill for ASR. In that range C is D[0] at exactly 32 for LSL, D[31] at exactly 32 for LSR, 0 above 32 for LSL and LSR, and D[31] for ASR. ROR rotates by the amount modulo 32, and C becomes bit 31 of the result. V is unchanged.
- R6: A shift amount of zero in S[7:0] returns D unchanged and leaves C unchanged, even when the upper bits of S are not zero.
- R7: ADC=5 computes D+S+C. SBC=6 computes D-S-(1-C). In both, C is the carry out (for subtraction, 1 means no borrow) and V is the signed overflow.
- R8: RSB=9 computes 0-S. C is 1 only when S is 0, and V is 1 only when S is 0x80000000.
- R9: CMP sets the flags from D-S, with C=1 when D is not less than S as unsigned values. CMN sets the flags from D+S.
- R10: MUL=13 returns the low 32 bits of D*S and leaves C and V unchanged.
- R11: `rst` is synchronous and active high, and it clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| instr_vld | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| src_val | input | 32 | Value of the register named by bits 5:3 |
| dst_val | input | 32 | Value of the register named by bits 2:0 |
| res | output | 32 | Computed value |
| wr_en | output | 1 | Write `res` to register `wr_idx` |
| wr_idx | output | 3 | Destination register index |
| flags | output | 4 | Condition flags {N,Z,C,V} |

## Verification
The bench aims at the shift amount boundaries: 0, 0x100, 1, 31, 32, 33 and 255, and ROR by 32 and 64. A design that ignored the upper bits of the amount would shift when it should not. A design that masked the amount to five bits would return D at 32 instead of zero or sign fill. The carry chains are driven across borrow, the most negative value and the sign boundary, with both values of C. A wrong carry-in polarity in SBC, or a V built from the wrong operand signs, shows up in the flags after the edge. The compare codes are checked for a stray register write. Logic codes and MUL are run right after C and V have been set to 1, so that any unwanted clearing is seen.

// File: rtl/regop_pkg.sv
package regop_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_EOR = 4'd1,
    OP_LSL = 4'd2,
    OP_LSR = 4'd3,
    OP_ASR = 4'd4,
    OP_ADC = 4'd5,
    OP_SBC = 4'd6,
    OP_ROR = 4'd7,
    OP_TST = 4'd8,
    OP_RSB = 4'd9,
    OP_CMP = 4'd10,
    OP_CMN = 4'd11,
    OP_ORR = 4'd12,
    OP_MUL = 4'd13,
    OP_BIC = 4'd14,
    OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2,
    SH_ROT   = 2'd3
  } shift_kind_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/regop_decode.sv
module regop_decode
  import regop_pkg::*;
#(
  parameter int INSTR_W   = 16,
  parameter int REG_IDX_W = 3
) (
  input  logic                 vld,
  input  logic [INSTR_W-1:0]   instr,
  output logic                 hit,
  output alu_op_e              op,
  output logic [REG_IDX_W-1:0] rs_idx,
  output logic [REG_IDX_W-1:0] rd_idx,
  output logic                 writes
);
  localparam int OPC_LSB = 2 * REG_IDX_W;
  localparam int OPC_MSB = OPC_LSB + 3;
  localparam int GRP_LSB = OPC_MSB + 1;
  localparam int GRP_W   = INSTR_W - GRP_LSB;
  localparam logic [GRP_W-1:0] GROUP_CODE = GRP_W'(6'b010000);

  logic flag_only;

  always_comb begin
    hit       = vld && (instr[INSTR_W-1:GRP_LSB] == GROUP_CODE);
    op        = alu_op_e'(instr[OPC_MSB:OPC_LSB]);
    rs_idx    = instr[OPC_LSB-1:REG_IDX_W];
    rd_idx    = instr[REG_IDX_W-1:0];
    flag_only = (op == OP_TST) || (op == OP_CMP) || (op == OP_CMN);
    writes    = hit && !flag_only;
  end

endmodule

// File: rtl/regop_shifter.sv
module regop_shifter
  import regop_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  shift_kind_e      kind,
  input  logic [W-1:0]     val,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     res,
  output logic             c_out
);
  localparam int LG = $clog2(W);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(W);

  // Each helper returns {carry, value}.
  function automatic logic [W:0] f_left(input logic [W-1:0] v, input logic [AMT_W-1:0] a);
    logic [W:0] t;
    if (a > AMT_FULL) return '0;
    t = {1'b0, v} << a;
    return t;
  endfunction

  function automatic logic [W:0] f_right(input logic [W-1:0] v, input logic [AMT_W-1:0] a);
    logic [W:0] t;
    if (a > AMT_FULL) return '0;
    t = {v, 1'b0} >> a;
    return {t[0], t[W:1]};
  endfunction

  function automatic logic [W:0] f_arith(input logic [W-1:0] v, input logic [AMT_W-1:0] a);
    logic [W:0] t;
    logic [AMT_W-1:0] s;
    s = (a > AMT_FULL) ? AMT_FULL : a;
    t = $signed({v, 1'b0}) >>> s;
    return {t[0], t[W:1]};
  endfunction

  function automatic logic [W:0] f_rot(input logic [W-1:0] v, input logic [AMT_W-1:0] a);
    logic [LG-1:0] r;
    logic [W-1:0]  o;
    r = a[LG-1:0];
    o = (v >> r) | (v << (W - int'(r)));
    return {o[W-1], o};
  endfunction

  logic [W:0] packed_out;

  always_comb begin
    unique case (kind)
      SH_LEFT:  packed_out = f_left(val, amt);
      SH_RIGHT: packed_out = f_right(val, amt);
      SH_ARITH: packed_out = f_arith(val, amt);
      default:  packed_out = f_rot(val, amt);
    endcase
    res   = packed_out[W-1:0];
    c_out = packed_out[W];
  end

endmodule

// File: rtl/regop_exec.sv
module regop_exec
  import regop_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] s_val,
  input  logic [W-1:0] d_val,
  input  logic         c_in,
  output logic [W-1:0] result,
  output logic         c_new,
  output logic         v_new,
  output logic         c_upd,
  output logic         v_upd,
  output logic         shift_zero
);
  // Returns {carry, overflow, sum}.
  function automatic logic [W+1:0] add_cv(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic cin);
    logic [W:0] s;
    logic       ov;
    s  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    ov = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    return {s[W], ov, s[W-1:0]};
  endfunction

  shift_kind_e      sh_kind;
  logic [W-1:0]     sh_res;
  logic             sh_c;
  logic [AMT_W-1:0] sh_amt;
  logic             is_shift;
  logic [W+1:0]     sum;

  assign sh_amt     = s_val[AMT_W-1:0];
  assign is_shift   = (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR);
  assign shift_zero = is_shift && (sh_amt == '0);

  always_comb begin
    unique case (op)
      OP_LSL:  sh_kind = SH_LEFT;
      OP_LSR:  sh_kind = SH_RIGHT;
      OP_ASR:  sh_kind = SH_ARITH;
      default: sh_kind = SH_ROT;
    endcase
  end

  regop_shifter #(.W(W), .AMT_W(AMT_W)) u_shift (
    .kind  (sh_kind),
    .val   (d_val),
    .amt   (sh_amt),
    .res   (sh_res),
    .c_out (sh_c)
  );

  always_comb begin
    unique case (op)
      OP_ADC:  sum = add_cv(d_val, s_val, c_in);
      OP_SBC:  sum = add_cv(d_val, ~s_val, c_in);
      OP_RSB:  sum = add_cv('0, ~s_val, 1'b1);
      OP_CMP:  sum = add_cv(d_val, ~s_val, 1'b1);
      OP_CMN:  sum = add_cv(d_val, s_val, 1'b0);
      default: sum = '0;
    endcase
  end

  always_comb begin
    result = '0;
    c_new  = c_in;
    v_new  = 1'b0;
    c_upd  = 1'b0;
    v_upd  = 1'b0;
    unique case (op)
      OP_AND, OP_TST: result = d_val & s_val;
      OP_EOR:         result = d_val ^ s_val;
      OP_ORR:         result = d_val | s_val;
      OP_BIC:         result = d_val & ~s_val;
      OP_MVN:         result = ~s_val;
      OP_MUL:         result = W'(d_val * s_val);
      OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
        if (shift_zero) begin
          result = d_val;
        end else begin
          result = sh_res;
          c_new  = sh_c;
          c_upd  = 1'b1;
        end
      end
      default: begin
        result = sum[W-1:0];
        c_new  = sum[W+1];
        v_new  = sum[W];
        c_upd  = 1'b1;
        v_upd  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/regop_flags.sv
module regop_flags
  import regop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic [W-1:0]         result,
  input  logic                 c_upd,
  input  logic                 c_new,
  input  logic                 v_upd,
  input  logic                 v_new,
  output logic [NUM_FLAGS-1:0] q
);
  logic [NUM_FLAGS-1:0] en;
  logic [NUM_FLAGS-1:0] nxt;

  always_comb begin
    en          = '0;
    nxt         = '0;
    en[FLAG_N]  = upd;
    en[FLAG_Z]  = upd;
    en[FLAG_C]  = upd && c_upd;
    en[FLAG_V]  = upd && v_upd;
    nxt[FLAG_N] = result[W-1];
    nxt[FLAG_Z] = (result == '0);
    nxt[FLAG_C] = c_new;
    nxt[FLAG_V] = v_new;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= 1'b0;
      else if (en[g]) q[g] <= nxt[g];
    end
  end

  // R1: the flags do not move without a recognised instruction
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(q));

  // R3: N and Z follow the computed value
  p_nz_track_r3: assert property (@(posedge clk) disable iff (rst)
    upd |=> (q[FLAG_N] == $past(result[W-1])) && (q[FLAG_Z] == ($past(result) == '0)));

endmodule

// File: rtl/regop_alu.sv
module regop_alu
  import regop_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int INSTR_W   = 16,
  parameter int REG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instr_vld,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    src_val,
  input  logic [DATA_W-1:0]    dst_val,
  output logic [DATA_W-1:0]    res,
  output logic                 wr_en,
  output logic [REG_IDX_W-1:0] wr_idx,
  output logic [3:0]           flags
);
  localparam int SHIFT_AMT_W = 8;
  localparam int OPC_LSB     = 2 * REG_IDX_W;
  localparam int GRP_LSB     = OPC_LSB + 4;

  alu_op_e              op;
  logic                 hit;
  logic [REG_IDX_W-1:0] rs_idx;
  logic                 c_new, v_new, c_upd, v_upd, shift_zero;
  logic [3:0]           opc_raw;
  logic                 grp_raw;

  regop_decode #(.INSTR_W(INSTR_W), .REG_IDX_W(REG_IDX_W)) u_dec (
    .vld    (instr_vld),
    .instr  (instr),
    .hit    (hit),
    .op     (op),
    .rs_idx (rs_idx),
    .rd_idx (wr_idx),
    .writes (wr_en)
  );

  regop_exec #(.W(DATA_W), .AMT_W(SHIFT_AMT_W)) u_exec (
    .op         (op),
    .s_val      (src_val),
    .d_val      (dst_val),
    .c_in       (flags[FLAG_C]),
    .result     (res),
    .c_new      (c_new),
    .v_new      (v_new),
    .c_upd      (c_upd),
    .v_upd      (v_upd),
    .shift_zero (shift_zero)
  );

  regop_flags #(.W(DATA_W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .upd    (hit),
    .result (res),
    .c_upd  (c_upd),
    .c_new  (c_new),
    .v_upd  (v_upd),
    .v_new  (v_new),
    .q      (flags)
  );

  // Raw instruction fields, taken apart independently of the decoder
  assign opc_raw = instr[OPC_LSB+3:OPC_LSB];
  assign grp_raw = instr_vld && (instr[INSTR_W-1:GRP_LSB] == (INSTR_W-GRP_LSB)'(6'b010000));

  // R1: nothing outside the group writes a register
  p_reject_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    !grp_raw |-> !wr_en);

  // R2: compare and test forms never write
  p_cmp_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (grp_raw && (opc_raw == 4'd8 || opc_raw == 4'd10 || opc_raw == 4'd11)) |-> !wr_en);

  // R4: logic forms leave C and V alone
  p_logic_keeps_cv_r4: assert property (@(posedge clk) disable iff (rst)
    (grp_raw && (opc_raw == 4'd0 || opc_raw == 4'd1 || opc_raw == 4'd8 ||
                 opc_raw == 4'd12 || opc_raw == 4'd14 || opc_raw == 4'd15))
    |=> $stable(flags[FLAG_C:FLAG_V]));

  // R4: a register combined with itself by EOR gives zero
  p_self_eor_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && opc_raw == 4'd1 && rs_idx == wr_idx && src_val == dst_val) |-> (res == '0));

  // R6: zero shift amount passes the value through and keeps C
  p_shift0_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && shift_zero) |-> (res == dst_val));
  p_shift0_keeps_c_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && shift_zero) |=> $stable(flags[FLAG_C]));

  // R10: multiply keeps C and V
  p_mul_keeps_cv_r10: assert property (@(posedge clk) disable iff (rst)
    (grp_raw && opc_raw == 4'd13) |=> $stable(flags[FLAG_C:FLAG_V]));

endmodule

// File: tb/tb_regop_alu.sv
module tb_regop_alu;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_vld;
  logic [15:0] instr;
  logic [31:0] src_val;
  logic [31:0] dst_val;
  logic [31:0] res;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;

  logic [31:0] regs [8];
  logic [3:0]  rf;

  always #5 clk = ~clk;

  regop_alu dut (
    .clk, .rst, .instr_vld, .instr, .src_val, .dst_val,
    .res, .wr_en, .wr_idx, .flags
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model; flag layout {N,Z,C,V}
  task automatic model(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                       input logic [3:0] fin, output logic [31:0] r, output logic [3:0] fo,
                       output logic we);
    logic        c, v;
    logic [7:0]  amt;
    logic [63:0] w;
    logic [32:0] t;
    c   = fin[1];
    v   = fin[0];
    amt = s[7:0];
    we  = !(op == 4'd8 || op == 4'd10 || op == 4'd11);
    r   = '0;
    case (op)
      4'd0, 4'd8: r = d & s;
      4'd1:  r = d ^ s;
      4'd12: r = d | s;
      4'd14: r = d & ~s;
      4'd15: r = ~s;
      4'd13: begin w = 64'(d) * 64'(s); r = w[31:0]; end
      4'd2: begin
        if (amt == 0) r = d;
        else begin w = {32'b0, d} << amt; r = w[31:0]; c = w[32]; end
      end
      4'd3: begin
        if (amt == 0) r = d;
        else begin w = {d, 32'b0} >> amt; r = w[63:32]; c = w[31]; end
      end
      4'd4: begin
        if (amt == 0) r = d;
        else begin
          w = $signed({d, 32'b0}) >>> ((amt > 63) ? 8'd63 : amt);
          r = w[63:32]; c = w[31];
        end
      end
      4'd7: begin
        r = d;
        if (amt != 0) begin
          for (int i = 0; i < int'(amt[4:0]); i++) r = {r[0], r[31:1]};
          c = r[31];
        end
      end
      4'd5, 4'd11: begin
        t = {1'b0, d} + {1'b0, s} + ((op == 4'd5) ? {32'b0, c} : 33'd0);
        r = t[31:0]; c = t[32];
        v = (d[31] == s[31]) && (r[31] != d[31]);
      end
      4'd6, 4'd10: begin
        t = {1'b0, d} - {1'b0, s} - ((op == 4'd6) ? {32'b0, !c} : 33'd0);
        r = t[31:0]; c = !t[32];
        v = (d[31] != s[31]) && (r[31] != d[31]);
      end
      default: begin
        r = 32'd0 - s; c = (s == 0); v = (s == 32'h8000_0000);
      end
    endcase
    fo = {r[31], r == 0, c, v};
  endtask

  // Drive one instruction word, check outputs before the edge and flags after it
  task automatic apply(input logic [15:0] ins, input logic vld, input string req);
    logic        hit, we;
    logic [31:0] r;
    logic [3:0]  fo;
    @(negedge clk);
    instr     = ins;
    instr_vld = vld;
    src_val   = regs[ins[5:3]];
    dst_val   = regs[ins[2:0]];
    hit = vld && (ins[15:10] == 6'b010000);
    model(ins[9:6], dst_val, src_val, rf, r, fo, we);
    we = we && hit;
    #1;
    check({req, " wr_en"}, {31'b0, wr_en}, {31'b0, we});
    if (hit) check({req, " wr_idx R1"}, {29'b0, wr_idx}, {29'b0, ins[2:0]});
    if (we)  check({req, " res"}, res, r);
    @(posedge clk);
    #1;
    if (hit) rf = fo;
    check({req, " flags"}, {28'b0, flags}, {28'b0, rf});
    if (we) regs[ins[2:0]] = r;
  endtask

  function automatic logic [15:0] mk(input logic [3:0] op, input int rs, input int rd);
    return {6'b010000, op, 3'(rs), 3'(rd)};
  endfunction

  task automatic run(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                     input string req);
    regs[1] = s;
    regs[2] = d;
    apply(mk(op, 1, 2), 1'b1, req);
  endtask

  task automatic set_flags_all_cv();
    run(4'd10, 32'h0, 32'h0, "R9 CMP setup");
    run(4'd5, 32'h8000_0000, 32'h8000_0000, "R7 ADC setup");
  endtask

  task automatic t_reset();
    rst = 1'b1; instr_vld = 1'b0; instr = '0; src_val = '0; dst_val = '0;
    repeat (2) @(posedge clk);
    #1;
    rf = 4'b0;
    check("R11 reset flags", {28'b0, flags}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_mid();
    set_flags_all_cv();
    @(negedge clk);
    rst = 1'b1;
    instr_vld = 1'b1;
    instr = mk(4'd9, 1, 2);
    @(posedge clk);
    #1;
    rf = 4'b0;
    check("R11 reset clears set flags", {28'b0, flags}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    instr_vld = 1'b0;
  endtask

  task automatic t_reject();
    set_flags_all_cv();
    regs[3] = 32'h0; regs[4] = 32'h0;
    apply({6'b010001, 4'd0, 3'd3, 3'd4}, 1'b1, "R1 wrong group");
    apply({6'b110000, 4'd9, 3'd3, 3'd4}, 1'b1, "R1 wrong group high");
    apply(mk(4'd0, 3, 4), 1'b0, "R1 not valid");
  endtask

  task automatic t_logic();
    set_flags_all_cv();
    run(4'd0, 32'hF0F0_1234, 32'h0FF0_FF00, "R4 AND");
    run(4'd1, 32'hAAAA_5555, 32'hAAAA_5555, "R4 EOR to zero");
    run(4'd12, 32'h8000_0000, 32'h0000_0001, "R4 ORR");
    run(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, "R4 BIC");
    run(4'd15, 32'h1234_5678, 32'h0000_0000, "R4 MVN");
    run(4'd8, 32'h0000_00F0, 32'h0000_000F, "R2 TST zero");
    regs[5] = 32'h5A5A_5A5A;
    apply(mk(4'd1, 5, 5), 1'b1, "R4 EOR same register");
  endtask

  task automatic t_shift();
    logic [31:0] amts [9] = '{32'd0, 32'h100, 32'd1, 32'd31, 32'd32, 32'd33,
                              32'd255, 32'd64, 32'hFFFF_FF05};
    logic [3:0]  ops  [4] = '{4'd2, 4'd3, 4'd4, 4'd7};
    logic [31:0] vals [2] = '{32'h8000_0001, 32'h4321_8765};
    for (int k = 0; k < 2; k++)
      for (int o = 0; o < 4; o++)
        for (int a = 0; a < 9; a++) begin
          if (a == 0) set_flags_all_cv();
          run(ops[o], vals[k], amts[a], (amts[a][7:0] == 0) ? "R6 shift zero" : "R5 shift");
        end
  endtask

  task automatic t_arith();
    run(4'd10, 32'h1, 32'h2, "R9 CMP borrow");
    run(4'd5, 32'hFFFF_FFFF, 32'h0, "R7 ADC cin0");
    run(4'd10, 32'h5, 32'h5, "R9 CMP equal");
    run(4'd5, 32'hFFFF_FFFF, 32'h0, "R7 ADC cin1 wrap");
    run(4'd5, 32'h7FFF_FFFF, 32'h0, "R7 ADC overflow");
    run(4'd6, 32'h0, 32'h0, "R7 SBC after carry");
    run(4'd6, 32'h8000_0000, 32'h1, "R7 SBC overflow");
    run(4'd6, 32'h10, 32'h3, "R7 SBC no borrow");
    run(4'd9, 32'hDEAD_BEEF, 32'h0, "R8 RSB zero");
    run(4'd9, 32'h0, 32'h8000_0000, "R8 RSB min");
    run(4'd9, 32'h0, 32'h0000_0007, "R8 RSB pos");
    run(4'd10, 32'h8000_0000, 32'h1, "R9 CMP signed ovf");
    run(4'd11, 32'hFFFF_FFFF, 32'h1, "R9 CMN carry");
    run(4'd11, 32'h7FFF_FFFF, 32'h1, "R9 CMN ovf");
    run(4'd8, 32'h8000_0000, 32'hC000_0000, "R2 TST neg");
  endtask

  task automatic t_mul();
    set_flags_all_cv();
    run(4'd13, 32'h0001_0001, 32'h0001_0001, "R10 MUL");
    run(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 MUL wrap");
    run(4'd13, 32'h0001_0000, 32'h0001_0000, "R10 MUL zero");
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 16; op++)
      for (int j = 0; j < 3; j++) begin
        regs[(op + j) % 8]     = 32'h1357_9BDF * (op + 1) + 32'(j);
        regs[(op + j + 3) % 8] = 32'h0246_8ACE ^ (32'(j) << 5);
        apply(mk(4'(op), (op + j) % 8, (op + j + 3) % 8), 1'b1, "R2 sweep");
      end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 32'(i);
    rf = 4'b0;
    t_reset();
    t_logic();
    t_shift();
    t_arith();
    t_mul();
    t_reject();
    t_sweep();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule